// File: doc/BRIEF.md
# One-Time Fuse Array Controller

This block controls a one-time-programmable fuse array of eight banks, each holding 256 rows of eight bits. It sits on a simple byte-wide register bus. A small register file sets the target cell and starts timed operations. A separate window gives direct access to every row. Two timed operations exist. A program cycle blows one addressed fuse bit, and it runs only after an unlock key has been written. An explicit sense cycle reads one raw row into a sense-data register. Both operations hold a busy flag for a fixed number of clock cycles.

The row window returns either the fuse contents or a software override held in a shadow copy. Three per-bank lock vectors are inputs held steady after reset. They forbid reading, programming and overriding a bank. Failures are recorded in error flags. Completions are recorded in status flags. Both kinds of flag are cleared by writing ones to them. The fuse storage is a behavioural model that starts blank at reset.

Top module: `otp_fuse_ctrl`

## Requirements
- R1: After reset, register indices 0 to 6 all read 0x00. Bus address bit 11 = 0 selects a register by bits 2:0: 0 status, 1 error, 2 control, 3 upper address, 4 lower address, 5 sense data, 6 key.
- R2: When the key register holds 0xAA, writing control with bit 0 = 1 starts a program cycle. Status bit 7 (busy) is then set for exactly OP_CYCLES cycles, and control bit 0 reads 1 during that time. At the end, the addressed fuse bit becomes 1, status bit 1 (program done) is set and control bit 0 returns to 0.
- R3: The upper address register holds the bank in bits 5:3 and row bits 7:5 in bits 2:0. The lower address register holds row bits 4:0 in bits 7:3 and the bit index in bits 2:0.
- R4: A program start is refused in two cases: the key register is not 0xAA, or the target bank's write lock is set. A refused start does not assert busy, blows no fuse, leaves program done clear and sets error bit 6.
- R5: Writing control with bit 3 = 1 starts a sense cycle of OP_CYCLES busy cycles. At its end, the raw fuse row is copied into the sense-data register and status bit 0 (sense done) is set. If the bank's read lock is set, no sense runs and error bit 2 is set instead.
- R6: Writing control with bits 0 and 3 both set starts nothing and sets error bit 7. Any write to control while busy is ignored, and the target is held for the whole operation.
- R7: Writing ones to the status or error register clears exactly those flags. Status bit 7 cannot be cleared this way. If a flag is set and cleared in the same cycle, it stays set.
- R8: Bus address bit 11 = 1 selects the row window: bits 10:8 give the bank and bits 7:0 give the row. A window read returns the override value if that row has one, and the fuse row otherwise. A window write stores an override, unless the bank's override lock is set; in that case it sets error bit 5 and changes nothing. Sensing ignores overrides.
- R9: A window read of a read-locked bank returns 0x00 and sets error bit 4.
- R10: Programming a fuse bit that is already blown leaves it at 1 and completes normally with program done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Bit 11 selects the row window; otherwise bits 2:0 select a register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the same cycle as a read access |
| rd_lock | input | 8 | Per-bank read lock |
| wr_lock | input | 8 | Per-bank program lock |
| ovr_lock | input | 8 | Per-bank override lock |

## Verification
The collision that matters is a completing operation setting its done flag in the same cycle that software writes a one to clear that flag. The bench provokes it by starting a sense and counting exactly OP_CYCLES-1 idle cycles. It then issues the status clear so that it lands on the finishing edge, and a status read must still show sense done (R7). A second overlap places a control write inside a running program. Here the control readback and the final fuse contents must show that the write was dropped. A behavioural model predicts every read value on every cycle.

// File: rtl/otp_fuse_pkg.sv
package otp_fuse_pkg;
  localparam int BANK_W = 3;
  localparam int ROW_W  = 8;
  localparam int BIT_W  = 3;
  localparam int DATA_W = 1 << BIT_W;
  localparam int IDX_W  = BANK_W + ROW_W;
  localparam int ADDR_W = IDX_W + 1;
  localparam int HI_W   = BANK_W + (ROW_W - (DATA_W - BIT_W));
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [DATA_W-1:0] PROG_KEY = 8'hAA;

  // status bits
  localparam int ST_BUSY = 7;
  localparam int ST_PRGD = 1;
  localparam int ST_SNSD = 0;
  // error bits
  localparam int ER_PRG  = 7;
  localparam int ER_WPRT = 6;
  localparam int ER_OPRT = 5;
  localparam int ER_RPRT = 4;
  localparam int ER_SNS  = 2;
  // control bits
  localparam int CT_PRG  = 0;
  localparam int CT_SNS  = 3;

  typedef enum logic [2:0] {
    RG_STATUS = 3'd0,
    RG_ERROR  = 3'd1,
    RG_CTRL   = 3'd2,
    RG_ADR_HI = 3'd3,
    RG_ADR_LO = 3'd4,
    RG_SENSE  = 3'd5,
    RG_KEY    = 3'd6,
    RG_NONE   = 3'd7
  } reg_idx_e;
endpackage

// File: rtl/otp_w1c_flags.sv
module otp_w1c_flags #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q, flags_d;
  logic         upd;

  // a set in the same cycle as a clear wins
  always_comb begin
    flags_d = (flags_q & ~clr_i) | set_i;
    upd     = |(set_i | clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flags_q <= '0;
    else if (upd) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/otp_fuse_array.sv
module otp_fuse_array
  import otp_fuse_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              blow_en,
  input  logic [IDX_W-1:0]  blow_addr,
  input  logic [BIT_W-1:0]  blow_bit,
  input  logic              ovr_en,
  input  logic [IDX_W-1:0]  ovr_addr,
  input  logic [DATA_W-1:0] ovr_data,
  input  logic [IDX_W-1:0]  win_addr,
  output logic [DATA_W-1:0] win_value,
  input  logic [IDX_W-1:0]  sns_addr,
  output logic [DATA_W-1:0] sns_value
);
  logic [DATA_W-1:0]  fuse_q   [ENTRIES];
  logic [DATA_W-1:0]  shadow_q [ENTRIES];
  logic [ENTRIES-1:0] ovr_q;

  // behavioural fuse cells: blank after reset, bits only ever set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) fuse_q[i] <= '0;
    end else if (blow_en) begin
      fuse_q[blow_addr] <= fuse_q[blow_addr] | (DATA_W'(1) << blow_bit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ovr_q <= '0;
    else if (ovr_en) ovr_q[ovr_addr] <= 1'b1;
  end

  // shadow contents are only visible once the valid bit is set
  always_ff @(posedge clk) begin
    if (ovr_en) shadow_q[ovr_addr] <= ovr_data;
  end

  assign win_value = ovr_q[win_addr] ? shadow_q[win_addr] : fuse_q[win_addr];
  assign sns_value = fuse_q[sns_addr];
endmodule

// File: rtl/otp_fuse_seq.sv
module otp_fuse_seq
  import otp_fuse_pkg::*;
#(
  parameter int OP_CYCLES = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_prg,
  input  logic             start_sns,
  input  logic [IDX_W-1:0] start_addr,
  input  logic [BIT_W-1:0] start_bit,
  output logic             busy,
  output logic             is_prg,
  output logic             fin_prg,
  output logic             fin_sns,
  output logic [IDX_W-1:0] tgt_addr,
  output logic [BIT_W-1:0] tgt_bit
);
  localparam int CNT_W = (OP_CYCLES > 1) ? $clog2(OP_CYCLES) : 1;

  logic             busy_q, busy_d;
  logic             prg_q, prg_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] addr_q, addr_d;
  logic [BIT_W-1:0] bit_q, bit_d;
  logic             last, load, en;

  assign last = busy_q && (cnt_q == '0);
  assign load = !busy_q && (start_prg || start_sns);
  assign en   = busy_q || load;

  always_comb begin
    busy_d = busy_q;
    prg_d  = prg_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    bit_d  = bit_q;
    if (busy_q) begin
      if (last) busy_d = 1'b0;
      else      cnt_d  = cnt_q - 1'b1;
    end else if (load) begin
      busy_d = 1'b1;
      prg_d  = start_prg;
      cnt_d  = CNT_W'(OP_CYCLES - 1);
      addr_d = start_addr;
      bit_d  = start_bit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      prg_q  <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      bit_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      prg_q  <= prg_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      bit_q  <= bit_d;
    end
  end

  assign busy     = busy_q;
  assign is_prg   = prg_q;
  assign fin_prg  = last && prg_q;
  assign fin_sns  = last && !prg_q;
  assign tgt_addr = addr_q;
  assign tgt_bit  = bit_q;
endmodule

// File: rtl/otp_fuse_ctrl.sv
module otp_fuse_ctrl
  import otp_fuse_pkg::*;
#(
  parameter int OP_CYCLES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [7:0]        rd_lock,
  input  logic [7:0]        wr_lock,
  input  logic [7:0]        ovr_lock
);
  localparam int LO_ROW_W = DATA_W - BIT_W;

  logic              wr_en, rd_en, win_hit;
  reg_idx_e          rsel;
  logic [IDX_W-1:0]  win_addr;
  logic [BANK_W-1:0] win_bank;

  logic [HI_W-1:0]   hi_q, hi_d;
  logic [DATA_W-1:0] lo_q, lo_d, key_q, key_d, sdat_q, sdat_d;
  logic              cfg_en;

  logic [IDX_W-1:0]  cur_addr;
  logic [BANK_W-1:0] cur_bank;
  logic [BIT_W-1:0]  cur_bit;

  logic              ctrl_wr, req_prg, req_sns, both_req;
  logic              go_prg, go_sns, deny_prg, deny_sns;
  logic              busy, is_prg, fin_prg, fin_sns;
  logic [IDX_W-1:0]  tgt_addr;
  logic [BIT_W-1:0]  tgt_bit;

  logic              ovr_en, ovr_deny, rd_deny;
  logic [DATA_W-1:0] win_value, sns_value;

  logic [1:0]        stat_set, stat_clr, stat_q;
  logic [DATA_W-1:0] err_set, err_clr, err_q;

  // ---- decode
  assign wr_en    = bus_sel && bus_wr;
  assign rd_en    = bus_sel && !bus_wr;
  assign win_hit  = bus_addr[ADDR_W-1];
  assign rsel     = reg_idx_e'(bus_addr[2:0]);
  assign win_addr = bus_addr[IDX_W-1:0];
  assign win_bank = bus_addr[IDX_W-1 -: BANK_W];

  assign cur_addr = {hi_q, lo_q[DATA_W-1 -: LO_ROW_W]};
  assign cur_bank = hi_q[HI_W-1 -: BANK_W];
  assign cur_bit  = lo_q[BIT_W-1:0];

  // ---- operation requests
  assign ctrl_wr  = wr_en && !win_hit && (rsel == RG_CTRL) && !busy;
  assign req_prg  = ctrl_wr && bus_wdata[CT_PRG];
  assign req_sns  = ctrl_wr && bus_wdata[CT_SNS];
  assign both_req = req_prg && req_sns;
  assign go_prg   = req_prg && !req_sns && (key_q == PROG_KEY) && !wr_lock[cur_bank];
  assign deny_prg = req_prg && !req_sns && !go_prg;
  assign go_sns   = req_sns && !req_prg && !rd_lock[cur_bank];
  assign deny_sns = req_sns && !req_prg && rd_lock[cur_bank];

  // ---- row window
  assign ovr_en   = wr_en && win_hit && !ovr_lock[win_bank];
  assign ovr_deny = wr_en && win_hit && ovr_lock[win_bank];
  assign rd_deny  = rd_en && win_hit && rd_lock[win_bank];

  // ---- configuration registers
  always_comb begin
    hi_d   = hi_q;
    lo_d   = lo_q;
    key_d  = key_q;
    sdat_d = sdat_q;
    if (wr_en && !win_hit) begin
      case (rsel)
        RG_ADR_HI: hi_d  = bus_wdata[HI_W-1:0];
        RG_ADR_LO: lo_d  = bus_wdata;
        RG_KEY:    key_d = bus_wdata;
        default: ;
      endcase
    end
    if (fin_sns) sdat_d = sns_value;
  end

  assign cfg_en = (wr_en && !win_hit) || fin_sns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      key_q  <= '0;
      sdat_q <= '0;
    end else if (cfg_en) begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      key_q  <= key_d;
      sdat_q <= sdat_d;
    end
  end

  // ---- timed operation sequencer
  otp_fuse_seq #(.OP_CYCLES(OP_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_prg  (go_prg),
    .start_sns  (go_sns),
    .start_addr (cur_addr),
    .start_bit  (cur_bit),
    .busy       (busy),
    .is_prg     (is_prg),
    .fin_prg    (fin_prg),
    .fin_sns    (fin_sns),
    .tgt_addr   (tgt_addr),
    .tgt_bit    (tgt_bit)
  );

  // ---- fuse storage and shadow copy
  otp_fuse_array u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .blow_en   (fin_prg),
    .blow_addr (tgt_addr),
    .blow_bit  (tgt_bit),
    .ovr_en    (ovr_en),
    .ovr_addr  (win_addr),
    .ovr_data  (bus_wdata),
    .win_addr  (win_addr),
    .win_value (win_value),
    .sns_addr  (tgt_addr),
    .sns_value (sns_value)
  );

  // ---- flags
  always_comb begin
    stat_set = '0;
    stat_set[ST_PRGD] = fin_prg;
    stat_set[ST_SNSD] = fin_sns;
    stat_clr = (wr_en && !win_hit && rsel == RG_STATUS) ? bus_wdata[1:0] : 2'b00;

    err_set = '0;
    err_set[ER_PRG]  = both_req;
    err_set[ER_WPRT] = deny_prg;
    err_set[ER_OPRT] = ovr_deny;
    err_set[ER_RPRT] = rd_deny;
    err_set[ER_SNS]  = deny_sns;
    err_clr = (wr_en && !win_hit && rsel == RG_ERROR) ? bus_wdata : '0;
  end

  otp_w1c_flags #(.W(2)) u_stat (
    .clk (clk), .rst_n (rst_n), .set_i (stat_set), .clr_i (stat_clr), .flags_o (stat_q)
  );

  otp_w1c_flags #(.W(DATA_W)) u_err (
    .clk (clk), .rst_n (rst_n), .set_i (err_set), .clr_i (err_clr), .flags_o (err_q)
  );

  // ---- read data
  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (win_hit) begin
        bus_rdata = rd_lock[win_bank] ? '0 : win_value;
      end else begin
        case (rsel)
          RG_STATUS: begin
            bus_rdata[ST_BUSY] = busy;
            bus_rdata[ST_PRGD] = stat_q[ST_PRGD];
            bus_rdata[ST_SNSD] = stat_q[ST_SNSD];
          end
          RG_ERROR: bus_rdata = err_q;
          RG_CTRL: begin
            bus_rdata[CT_PRG] = busy && is_prg;
            bus_rdata[CT_SNS] = busy && !is_prg;
          end
          RG_ADR_HI: bus_rdata[HI_W-1:0] = hi_q;
          RG_ADR_LO: bus_rdata = lo_q;
          RG_SENSE:  bus_rdata = sdat_q;
          RG_KEY:    bus_rdata = key_q;
          default:   bus_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/otp_fuse_ctrl_chk.sv
module otp_fuse_ctrl_chk
  import otp_fuse_pkg::*;
#(
  parameter int OP_CYCLES = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              is_prg,
  input logic [DATA_W-1:0] key,
  input logic [1:0]        stat,
  input logic [DATA_W-1:0] err,
  input logic [DATA_W-1:0] sdat,
  input logic [IDX_W-1:0]  tgt_addr
);
  int unsigned run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= 0;
    else if (busy) run_q <= run_q + 1;
    else           run_q <= 0;
  end

  AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_q == OP_CYCLES); // R2
  AST_PRGD_FROM_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[ST_PRGD]) |-> $past(busy && is_prg)); // R2
  AST_KEY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(busy) && is_prg) |-> $past(key) == PROG_KEY); // R4
  AST_DENY_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(err[ER_WPRT]) && !$past(busy)) |-> !busy); // R4
  AST_SNSD_FROM_OP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[ST_SNSD]) |-> $past(busy && !is_prg)); // R5
  AST_SDAT_ON_SENSE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sdat) |-> $past(busy && !is_prg)); // R5
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(tgt_addr)); // R6
endmodule

bind otp_fuse_ctrl otp_fuse_ctrl_chk #(.OP_CYCLES(OP_CYCLES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .is_prg   (is_prg),
  .key      (key_q),
  .stat     (stat_q),
  .err      (err_q),
  .sdat     (sdat_q),
  .tgt_addr (tgt_addr)
);

// File: tb/otp_fuse_ctrl_test.sv
module otp_fuse_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int OPC = 64;
  localparam logic [7:0] RDL = 8'h04;
  localparam logic [7:0] WRL = 8'h08;
  localparam logic [7:0] OVL = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [7:0]  rd_lock, wr_lock, ovr_lock;

  otp_fuse_ctrl #(.OP_CYCLES(OPC)) uut (
    .clk (clk), .rst_n (rst_n), .bus_sel (bus_sel), .bus_wr (bus_wr),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .rd_lock (rd_lock), .wr_lock (wr_lock), .ovr_lock (ovr_lock)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // ---- behavioural reference model
  bit [7:0]  m_fuse [2048];
  bit [7:0]  m_shadow [2048];
  bit        m_ovr [2048];
  bit        m_busy, m_isprg, m_prgd, m_snsd;
  int        m_left;
  int        m_tgt, m_tbit;
  bit [7:0]  m_err, m_lo, m_key, m_sdat;
  bit [5:0]  m_hi;

  function automatic bit [7:0] model_read(input bit [11:0] a);
    int idx;
    idx = a[10:0];
    if (a[11]) begin
      if (RDL[a[10:8]]) return 8'h00;
      return m_ovr[idx] ? m_shadow[idx] : m_fuse[idx];
    end
    case (a[2:0])
      3'd0: return {m_busy, 5'b0, m_prgd, m_snsd};
      3'd1: return m_err;
      3'd2: return {4'b0, m_busy && !m_isprg, 2'b0, m_busy && m_isprg};
      3'd3: return {2'b0, m_hi};
      3'd4: return m_lo;
      3'd5: return m_sdat;
      3'd6: return m_key;
      default: return 8'h00;
    endcase
  endfunction

  task automatic model_step(input bit wr, input bit [11:0] a, input bit [7:0] d);
    bit pre_busy, fp, fs;
    bit [7:0] eset;
    int bank;
    pre_busy = m_busy; fp = 0; fs = 0; eset = 0;
    if (m_busy) begin
      m_left--;
      if (m_left == 0) begin
        m_busy = 0;
        if (m_isprg) begin m_fuse[m_tgt] |= 8'(1 << m_tbit); fp = 1; end
        else begin m_sdat = m_fuse[m_tgt]; fs = 1; end
      end
    end
    if (wr) begin
      if (a[11]) begin
        if (OVL[a[10:8]]) eset[5] = 1;
        else begin m_shadow[a[10:0]] = d; m_ovr[a[10:0]] = 1; end
      end else begin
        case (a[2:0])
          3'd0: begin if (d[1]) m_prgd = 0; if (d[0]) m_snsd = 0; end
          3'd1: m_err &= ~d;
          3'd2: if (!pre_busy) begin
            bank = m_hi[5:3];
            if (d[0] && d[3]) eset[7] = 1;
            else if (d[0]) begin
              if (m_key == 8'hAA && !WRL[bank]) begin
                m_busy = 1; m_isprg = 1; m_left = OPC;
                m_tgt = {m_hi, m_lo[7:3]}; m_tbit = m_lo[2:0];
              end else eset[6] = 1;
            end else if (d[3]) begin
              if (RDL[bank]) eset[2] = 1;
              else begin
                m_busy = 1; m_isprg = 0; m_left = OPC;
                m_tgt = {m_hi, m_lo[7:3]}; m_tbit = m_lo[2:0];
              end
            end
          end
          3'd3: m_hi = d[5:0];
          3'd4: m_lo = d;
          3'd6: m_key = d;
          default: ;
        endcase
      end
    end else if (a[11] && RDL[a[10:8]]) eset[4] = 1;
    if (fp) m_prgd = 1;
    if (fs) m_snsd = 1;
    m_err |= eset;
  endtask

  task automatic check(input string tag, input bit [7:0] got, input bit [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h at %0t", tag, got, exp, $time);
    end
  endtask

  // one bus cycle; called at a falling edge, returns at the next falling edge
  task automatic op(input bit wr, input bit [11:0] a, input bit [7:0] d,
                    input string tag, input int lit = -1);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1;
    if (!wr) begin
      check(tag, bus_rdata, model_read(a));
      if (lit >= 0) check(tag, bus_rdata, 8'(lit));
    end
    @(posedge clk);
    model_step(wr, a, d);
    @(negedge clk);
  endtask

  task automatic idle(); op(0, 12'h000, 8'h00, "R2"); endtask
  task automatic wait_done(); while (m_busy) idle(); endtask
  function automatic bit [11:0] win(input int bank, input int row);
    return {1'b1, 3'(bank), 8'(row)};
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rd_lock = RDL; wr_lock = WRL; ovr_lock = OVL;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int i = 0; i < 7; i++) op(0, 12'(i), 8'h00, "R1", 0);

    // R2/R3 program bank0 row 0x25 bit5
    op(1, 12'h003, 8'h01, "R3"); op(1, 12'h004, 8'h2D, "R3");
    op(1, 12'h006, 8'hAA, "R2");
    op(1, 12'h002, 8'h01, "R2");
    op(0, 12'h002, 8'h00, "R2", 8'h01);
    op(0, 12'h000, 8'h00, "R2", 8'h80);
    wait_done();
    op(0, 12'h000, 8'h00, "R2", 8'h02);
    op(0, 12'h002, 8'h00, "R2", 8'h00);
    op(0, win(0, 8'h25), 8'h00, "R3", 8'h20);
    op(1, 12'h000, 8'h02, "R7");
    op(0, 12'h000, 8'h00, "R7", 8'h00);

    // R5 sense same row
    op(1, 12'h002, 8'h08, "R5");
    op(0, 12'h002, 8'h00, "R5", 8'h08);
    wait_done();
    op(0, 12'h005, 8'h00, "R5", 8'h20);
    op(0, 12'h000, 8'h00, "R5", 8'h01);
    op(1, 12'h000, 8'h01, "R7");

    // R4 wrong key
    op(1, 12'h006, 8'h55, "R4"); op(1, 12'h004, 8'h2C, "R4");
    op(1, 12'h002, 8'h01, "R4");
    op(0, 12'h000, 8'h00, "R4", 8'h00);
    op(0, 12'h001, 8'h00, "R4", 8'h40);
    op(0, win(0, 8'h25), 8'h00, "R4", 8'h20);
    op(1, 12'h001, 8'h40, "R7");
    op(0, 12'h001, 8'h00, "R7", 8'h00);

    // R4 write-locked bank 3
    op(1, 12'h006, 8'hAA, "R4"); op(1, 12'h003, 8'h18, "R4"); op(1, 12'h004, 8'h00, "R4");
    op(1, 12'h002, 8'h01, "R4");
    op(0, 12'h000, 8'h00, "R4", 8'h00);
    op(0, 12'h001, 8'h00, "R4", 8'h40);
    op(0, win(3, 0), 8'h00, "R4", 8'h00);
    op(1, 12'h001, 8'hFF, "R7");

    // R10 reprogram blown bit
    op(1, 12'h003, 8'h01, "R10"); op(1, 12'h004, 8'h2D, "R10");
    op(1, 12'h002, 8'h01, "R10");
    wait_done();
    op(0, 12'h000, 8'h00, "R10", 8'h02);
    op(0, win(0, 8'h25), 8'h00, "R10", 8'h20);
    op(1, 12'h000, 8'h03, "R7");

    // R6 both start bits
    op(1, 12'h002, 8'h09, "R6");
    op(0, 12'h000, 8'h00, "R6", 8'h00);
    op(0, 12'h001, 8'h00, "R6", 8'h80);

    // R5 sense of read-locked bank 2
    op(1, 12'h003, 8'h10, "R5");
    op(1, 12'h002, 8'h08, "R5");
    op(0, 12'h000, 8'h00, "R5", 8'h00);
    op(0, 12'h001, 8'h00, "R5", 8'h84);
    op(1, 12'h001, 8'hFF, "R7");

    // R8 override and sense ignoring it
    op(1, win(1, 7), 8'h5A, "R8");
    op(0, win(1, 7), 8'h00, "R8", 8'h5A);
    op(1, 12'h003, 8'h08, "R8"); op(1, 12'h004, 8'h38, "R8");
    op(1, 12'h002, 8'h08, "R8");
    wait_done();
    op(0, 12'h005, 8'h00, "R8", 8'h00);
    op(1, 12'h000, 8'h01, "R7");
    op(1, win(5, 3), 8'h77, "R8");
    op(0, 12'h001, 8'h00, "R8", 8'h20);
    op(0, win(5, 3), 8'h00, "R8", 8'h00);

    // R9 read-locked window
    op(0, win(2, 9), 8'h00, "R9", 8'h00);
    op(0, 12'h001, 8'h00, "R9", 8'h30);
    op(1, 12'h001, 8'h10, "R7");
    op(0, 12'h001, 8'h00, "R7", 8'h20);
    op(1, 12'h001, 8'hFF, "R7");

    // R6 control writes while busy are dropped; R7 busy not clearable
    op(1, 12'h002, 8'h01, "R6");
    op(1, 12'h002, 8'h08, "R6");
    op(0, 12'h002, 8'h00, "R6", 8'h01);
    op(1, 12'h000, 8'h80, "R7");
    op(0, 12'h000, 8'h00, "R7", 8'h80);
    wait_done();
    op(0, win(1, 7), 8'h00, "R8", 8'h5A);
    op(0, 12'h000, 8'h00, "R6", 8'h02);
    op(1, 12'h000, 8'h03, "R7");

    // R7 clear landing on the completion edge: set wins
    op(1, 12'h003, 8'h01, "R7"); op(1, 12'h004, 8'h28, "R7");
    op(1, 12'h002, 8'h08, "R7");
    for (int i = 0; i < OPC - 1; i++) idle();
    op(1, 12'h000, 8'h01, "R7");
    op(0, 12'h000, 8'h00, "R7", 8'h01);
    op(0, 12'h005, 8'h00, "R5", 8'h20);
    op(1, 12'h000, 8'h01, "R7");
    op(0, 12'h000, 8'h00, "R7", 8'h00);

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule